// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This unit gathers the four interrupt causes of a UART (receiver line status, received data or character timeout, transmitter holding register empty, and modem line change) and presents one identification byte. That byte reports the most urgent pending cause. Each cause is gated by a bit in a 4-bit enable register. The unit also keeps the modem-line change flags and shows whether the FIFOs are switched on. The serial shifters and FIFOs are outside the unit. It sees only their status: the receive FIFO fill count, a timeout level, a holding-empty level, a one-cycle line-error pulse and the four modem input levels.

The host reaches the unit through a 3-bit address with read and write strobes, decoded as follows:
- Offset 0, write: the holding register.
- Offset 1, write: interrupt enable.
- Offset 2, read: identification.
- Offset 2, write: FIFO control.
- Offset 5, read: line status.
- Offset 6, read: modem status.

Some of these accesses clear causes as a side effect. An active-high request line follows the pending state.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the identification byte is 0x01, the request line is low, all enables are 0, the FIFOs are off and the modem change flags are 0.
- R2: Identification bit 0 is 0 while an enabled cause is pending and 1 otherwise. The request line is always the inverse of bit 0.
- R3: Enable bits are as follows: bit 0 is received data, bit 1 is holding empty, bit 2 is line status and bit 3 is modem change. Identification bits [2:1] carry 11 for line status, 10 for received data, 01 for holding empty and 00 for modem change. Bits 5 and 4 always read 0, and bits [3:1] read 0 when nothing is pending.
- R4: When several enabled causes are pending, the reported one is the first of: line status, received data, holding empty, modem change.
- R5: With the FIFOs on, the received-data cause is active while the fill count is at least the trigger level. FIFO control bits [7:6] select the level: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14. With the FIFOs off the level is 1.
- R6: With the FIFOs on and the timeout input high, the received-data code is reported with identification bit 3 set. With the FIFOs off, the timeout input has no effect.
- R7: Identification bits [7:6] read 11 when FIFO control bit 0 was last written 1, and 00 otherwise.
- R8: A rising edge of the holding-empty input sets the holding-empty cause. It is cleared by a holding register write, or by an identification read while it is the reported cause.
- R9: An identification read while another cause is reported leaves a pending holding-empty cause in place.
- R10: The modem status byte has the current CTS, DSR, RI and DCD levels in bits 4, 5, 6 and 7. Its change flags are in bits 0, 1, 2 and 3. A flag sets when its level changes and clears when the modem status is read.
- R11: A line-error pulse latches the line-status cause until the line status is read.
- R12: A cause whose enable bit is 0 does not raise the request, but it stays latched. It is reported as soon as its enable bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostAddr | input | 3 | Host register offset |
| hostWr | input | 1 | Host write strobe |
| hostRd | input | 1 | Host read strobe |
| hostWdata | input | 8 | Host write data |
| rxCount | input | 5 | Receive FIFO fill count |
| rxTimeout | input | 1 | Character timeout level from the receiver |
| txHoldEmpty | input | 1 | Transmit holding register empty level |
| lineEvt | input | 1 | One-cycle pulse on a receive line error or break |
| ctsLvl | input | 1 | CTS input level |
| dsrLvl | input | 1 | DSR input level |
| riLvl | input | 1 | RI input level |
| dcdLvl | input | 1 | DCD input level |
| identByte | output | 8 | Identification byte |
| modemStatus | output | 8 | Modem levels and change flags |
| irqOut | output | 1 | Interrupt request, active high |

## Verification
On every cycle the assertions check:
- Bit 0 and the request line are consistent, and the reserved bits are 0.
- Bits [7:6] agree with each other.
- A pending enabled line-status cause always wins.
- The clearing reads actually clear: holding empty on an identification read while it is reported, and the modem flags on a modem status read.

Only the directed scenarios can show the rest:
- The exact trigger thresholds at each FIFO control setting.
- The full priority walk-down as each cause is cleared in turn.
- That a masked cause survives and appears once its enable bit is set.
- That an identification read does not clear a holding-empty cause that is hidden behind a higher one.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  typedef struct packed {
    logic enableWr;
    logic fifoCtlWr;
    logic holdWr;
    logic identRd;
    logic lineRd;
    logic modemRd;
  } hostStrobes_t;

  typedef enum logic [1:0] {
    CODE_MODEM = 2'b00,
    CODE_HOLD  = 2'b01,
    CODE_RXDAT = 2'b10,
    CODE_LINE  = 2'b11
  } irqCode_t;
endpackage

// File: rtl/uart_irq_decode.sv
module uart_irq_decode
  import uart_irq_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int OFS_HOLD = 0,
  parameter int OFS_EN   = 1,
  parameter int OFS_ID   = 2,
  parameter int OFS_LINE = 5,
  parameter int OFS_MDM  = 6
) (
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWr,
  input  logic              hostRd,
  output hostStrobes_t      stb
);
  always_comb begin
    stb = '0;
    stb.holdWr    = hostWr && (hostAddr == ADDR_W'(OFS_HOLD));
    stb.enableWr  = hostWr && (hostAddr == ADDR_W'(OFS_EN));
    stb.fifoCtlWr = hostWr && (hostAddr == ADDR_W'(OFS_ID));
    stb.identRd   = hostRd && (hostAddr == ADDR_W'(OFS_ID));
    stb.lineRd    = hostRd && (hostAddr == ADDR_W'(OFS_LINE));
    stb.modemRd   = hostRd && (hostAddr == ADDR_W'(OFS_MDM));
  end
endmodule

// File: rtl/uart_irq_core.sv
module uart_irq_core
  import uart_irq_pkg::*;
#(
  parameter int CNT_W     = 5,
  parameter int MODEM_N   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  hostStrobes_t       stb,
  input  logic [7:0]         hostWdata,
  input  logic [CNT_W-1:0]   rxCount,
  input  logic               rxTimeout,
  input  logic               txHoldEmpty,
  input  logic               lineEvt,
  input  logic [MODEM_N-1:0] modemIn,
  output logic [7:0]         identByte,
  output logic [2*MODEM_N-1:0] modemStatus,
  output logic               irqPending
);
  localparam int EN_W = 4;

  logic [EN_W-1:0]    enReg;
  logic               fifoOn;
  logic [1:0]         trigSel;
  logic               holdPend, prevEmpty, linePend;
  logic [MODEM_N-1:0] modemLvl, modemChg;

  function automatic logic [CNT_W-1:0] trigLevel(input logic [1:0] sel);
    case (sel)
      2'b00:   trigLevel = CNT_W'(1);
      2'b01:   trigLevel = CNT_W'(4);
      2'b10:   trigLevel = CNT_W'(8);
      default: trigLevel = CNT_W'(14);
    endcase
  endfunction

  // host-written configuration
  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg   <= '0;
      fifoOn  <= 1'b0;
      trigSel <= 2'b00;
    end else begin
      if (stb.enableWr) enReg <= hostWdata[EN_W-1:0];
      if (stb.fifoCtlWr) begin
        fifoOn  <= hostWdata[0];
        trigSel <= hostWdata[7:6];
      end
    end
  end

  // cause resolution
  logic     rxLevelHit, toHit, lineSrc, rxSrc, holdSrc, modemSrc;
  irqCode_t code;
  assign rxLevelHit = rxCount >= (fifoOn ? trigLevel(trigSel) : CNT_W'(1));
  assign toHit      = fifoOn && rxTimeout;
  assign lineSrc    = enReg[2] && linePend;
  assign rxSrc      = enReg[0] && (rxLevelHit || toHit);
  assign holdSrc    = enReg[1] && holdPend;
  assign modemSrc   = enReg[3] && (|modemChg);
  assign irqPending = lineSrc || rxSrc || holdSrc || modemSrc;

  always_comb begin
    if (lineSrc)      code = CODE_LINE;
    else if (rxSrc)   code = CODE_RXDAT;
    else if (holdSrc) code = CODE_HOLD;
    else              code = CODE_MODEM;
  end

  always_comb begin
    identByte      = '0;
    identByte[7:6] = {2{fifoOn}};
    identByte[0]   = !irqPending;
    if (irqPending) begin
      identByte[2:1] = code;
      identByte[3]   = (code == CODE_RXDAT) && toHit;
    end
  end

  // holding-empty cause
  logic emptyRise;
  assign emptyRise = txHoldEmpty && !prevEmpty;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdPend  <= 1'b0;
      prevEmpty <= 1'b0;
      linePend  <= 1'b0;
    end else begin
      prevEmpty <= txHoldEmpty;
      if (emptyRise)
        holdPend <= 1'b1;
      else if (stb.holdWr || (stb.identRd && irqPending && code == CODE_HOLD))
        holdPend <= 1'b0;
      if (lineEvt)         linePend <= 1'b1;
      else if (stb.lineRd) linePend <= 1'b0;
    end
  end

  // per-line change detection
  for (genvar i = 0; i < MODEM_N; i++) begin : g_modem
    always_ff @(posedge clk) begin
      if (!rstN) begin
        modemLvl[i] <= 1'b0;
        modemChg[i] <= 1'b0;
      end else begin
        modemLvl[i] <= modemIn[i];
        if (modemIn[i] != modemLvl[i]) modemChg[i] <= 1'b1;
        else if (stb.modemRd)          modemChg[i] <= 1'b0;
      end
    end
  end
  assign modemStatus = {modemLvl, modemChg};

  // R3 idle byte carries no code
  a_r3_idle_clean: assert property (@(posedge clk) disable iff (!rstN)
    identByte[0] |-> (identByte[5:1] == 5'b0));
  // R7 FIFO bits move together
  a_r7_fifo_bits: assert property (@(posedge clk) disable iff (!rstN)
    identByte[7] == identByte[6]);
  // R4 line status always wins
  a_r4_line_first: assert property (@(posedge clk) disable iff (!rstN)
    (enReg[2] && linePend) |-> (identByte[2:0] == 3'b110));
  // R8 reported holding-empty cleared by identification read
  a_r8_hold_clear: assert property (@(posedge clk) disable iff (!rstN)
    (stb.identRd && identByte[3:0] == 4'b0010 && !emptyRise) |=> !holdPend);
  // R10 modem read clears flags when no new change
  a_r10_modem_clear: assert property (@(posedge clk) disable iff (!rstN)
    (stb.modemRd && modemIn == modemLvl) |=> (modemChg == '0));
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [7:0]        hostWdata,
  input  logic [CNT_W-1:0]  rxCount,
  input  logic              rxTimeout,
  input  logic              txHoldEmpty,
  input  logic              lineEvt,
  input  logic              ctsLvl,
  input  logic              dsrLvl,
  input  logic              riLvl,
  input  logic              dcdLvl,
  output logic [7:0]        identByte,
  output logic [7:0]        modemStatus,
  output logic              irqOut
);
  hostStrobes_t stb;
  logic         irqPending;

  uart_irq_decode #(.ADDR_W(ADDR_W)) u_decode (
    .hostAddr(hostAddr), .hostWr(hostWr), .hostRd(hostRd), .stb(stb)
  );

  uart_irq_core #(.CNT_W(CNT_W), .MODEM_N(4)) u_core (
    .clk(clk), .rstN(rstN), .stb(stb), .hostWdata(hostWdata),
    .rxCount(rxCount), .rxTimeout(rxTimeout), .txHoldEmpty(txHoldEmpty),
    .lineEvt(lineEvt), .modemIn({dcdLvl, riLvl, dsrLvl, ctsLvl}),
    .identByte(identByte), .modemStatus(modemStatus), .irqPending(irqPending)
  );

  assign irqOut = irqPending;

  // R2 request line mirrors identification bit 0
  a_r2_irq_inverse: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == !identByte[0]);
endmodule

// File: tb/test_uart_irq_ident.sv
module test_uart_irq_ident;
  logic       clk = 0, rstN = 0;
  logic [2:0] hostAddr = 0;
  logic       hostWr = 0, hostRd = 0;
  logic [7:0] hostWdata = 0;
  logic [4:0] rxCount = 0;
  logic       rxTimeout = 0, txHoldEmpty = 0, lineEvt = 0;
  logic       ctsLvl = 0, dsrLvl = 0, riLvl = 0, dcdLvl = 0;
  logic [7:0] identByte, modemStatus;
  logic       irqOut;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  uart_irq_ident i_uart_irq_ident (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWr(hostWr),
    .hostRd(hostRd), .hostWdata(hostWdata), .rxCount(rxCount),
    .rxTimeout(rxTimeout), .txHoldEmpty(txHoldEmpty), .lineEvt(lineEvt),
    .ctsLvl(ctsLvl), .dsrLvl(dsrLvl), .riLvl(riLvl), .dcdLvl(dcdLvl),
    .identByte(identByte), .modemStatus(modemStatus), .irqOut(irqOut)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chkId(input string tag, input logic [7:0] exp);
    chk(tag, identByte, exp);
    chk({tag, " irq"}, {7'b0, irqOut}, {7'b0, ~exp[0]});
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    hostAddr = a; hostWdata = d; hostWr = 1;
    tick();
    hostWr = 0;
  endtask

  task automatic rd(input logic [2:0] a);
    hostAddr = a; hostRd = 1;
    tick();
    hostRd = 0;
  endtask

  task automatic pulseLine();
    lineEvt = 1; tick(); lineEvt = 0;
  endtask

  task automatic riseEmpty();
    txHoldEmpty = 0; tick(); txHoldEmpty = 1; tick();
  endtask

  task automatic testReset();
    chkId("R1 reset ident", 8'h01);
    chk("R1 reset modem", modemStatus, 8'h00);
  endtask

  task automatic testHold();
    wr(1, 8'h02);
    riseEmpty();
    chkId("R8 hold set", 8'h02);
    rd(2);
    chkId("R8 cleared by ident read", 8'h01);
    riseEmpty();
    chkId("R8 hold set again", 8'h02);
    wr(0, 8'h55);
    chkId("R8 cleared by holding write", 8'h01);
  endtask

  task automatic testHidden();
    wr(1, 8'h06);
    riseEmpty();
    pulseLine();
    chkId("R4 line over hold", 8'h06);
    rd(2);
    chkId("R9 ident read keeps hidden hold", 8'h06);
    rd(5);
    chkId("R11 line cleared, R9 hold remains", 8'h02);
    wr(0, 8'h00);
    chkId("R2 nothing pending", 8'h01);
  endtask

  task automatic testRx();
    wr(1, 8'h01);
    rxCount = 1; tick();
    chkId("R5 fifo off level 1", 8'h04);
    rxCount = 0; tick();
    chkId("R5 empty no irq", 8'h01);
    wr(2, 8'h81);
    chkId("R7 fifo on bits", 8'hC1);
    rxCount = 7; tick();
    chkId("R5 trigger 8 below", 8'hC1);
    rxCount = 8; tick();
    chkId("R5 trigger 8 hit", 8'hC4);
    wr(2, 8'hC1);
    rxCount = 13; tick();
    chkId("R5 trigger 14 below", 8'hC1);
    rxCount = 14; tick();
    chkId("R5 trigger 14 hit", 8'hC4);
    wr(2, 8'h41);
    rxCount = 3; tick();
    chkId("R5 trigger 4 below", 8'hC1);
    rxCount = 4; tick();
    chkId("R5 trigger 4 hit", 8'hC4);
    rxCount = 2; rxTimeout = 1; tick();
    chkId("R6 timeout flagged", 8'hCC);
    wr(2, 8'h00);
    rxCount = 0; tick();
    chkId("R6 R7 timeout ignored fifo off", 8'h01);
    rxTimeout = 0;
  endtask

  task automatic testModem();
    wr(1, 8'h08);
    ctsLvl = 1; tick();
    chk("R10 cts change", modemStatus, 8'h11);
    chkId("R3 modem code", 8'h00);
    rd(6);
    chk("R10 flags cleared", modemStatus, 8'h10);
    chkId("R10 no irq after read", 8'h01);
    dcdLvl = 1; tick();
    chk("R10 dcd change", modemStatus, 8'h98);
    rd(6);
    chk("R10 dcd cleared", modemStatus, 8'h90);
  endtask

  task automatic testMask();
    wr(1, 8'h00);
    pulseLine();
    chkId("R12 masked line", 8'h01);
    wr(1, 8'h04);
    chkId("R12 unmasked line shows", 8'h06);
    rd(5);
    chkId("R11 line cleared", 8'h01);
  endtask

  task automatic testPriority();
    wr(1, 8'h0F);
    pulseLine();
    rxCount = 1;
    riseEmpty();
    riLvl = 1; tick();
    chkId("R4 all pending line", 8'h06);
    rd(5);
    chkId("R4 then rx", 8'h04);
    rxCount = 0; tick();
    chkId("R4 then hold", 8'h02);
    wr(0, 8'h00);
    chkId("R4 then modem", 8'h00);
    rd(6);
    chkId("R4 all clear", 8'h01);
  endtask

  initial begin
    fork
      begin
        repeat (3) tick();
        rstN = 1;
        tick();
        testReset();
        testHold();
        testHidden();
        testRx();
        testModem();
        testMask();
        testPriority();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule